// File: doc/BRIEF.md
# Segment Selector Translation and Protection Check

This block turns a segment selector and a 32-bit offset into a linear address, as a protected-mode address unit does. It owns two small descriptor tables, one global and one local. Each entry holds a 32-bit base, a 20-bit limit, a granularity flag, a two-bit descriptor privilege level and a present flag. Software-side logic fills them through a write port, one entry per cycle.

On a request the block decodes the selector and reads the chosen entry. It then checks, in a fixed priority order, for a null selector, a missing descriptor, a privilege violation and an offset beyond the segment end. The result appears one clock after the request. It is either a valid linear address (base plus offset) or a fault code. A mode input limits the produced address to 24 bits for a narrow address bus.

Top module: `seg_xlate`

## Requirements
- R1: After reset all outputs are zero and every descriptor in both tables is marked not present.
- R2: When `wr_en` is high, the entry at `wr_idx` of the table chosen by `wr_local` (0 global, 1 local) takes the write fields at the clock edge. A write with `wr_idx` at or beyond the table depth changes nothing.
- R3: The selector carries the entry index in bits 15:3, the table choice in bit 2 (0 global, 1 local) and the requested privilege in bits 1:0.
- R4: A selector with index 0 and bit 2 clear gives fault code 1 (null), whatever its privilege bits. Local index 0 is an ordinary entry.
- R5: A descriptor whose present flag is clear, or an index at or beyond the chosen table's depth, gives fault code 2.
- R6: Let the effective level be the larger of `cur_pl` and the requested level. If this level is greater than the descriptor privilege, the result is fault code 3.
- R7: The segment end is the raw limit in bytes when granularity is 0, or the limit shifted left 12 bits with FFFH in the low bits when granularity is 1. An offset greater than the end gives fault code 4.
- R8: When several faults apply, code 1 wins over 2, 2 over 3, and 3 over 4.
- R9: With no fault, `addr_ok` is high, `fault_code` is 0 and `lin_addr` is base plus offset modulo 2^32.
- R10: When `narrow` is high, bits 31:24 of `lin_addr` are zero and the low 24 bits are those of base plus offset.
- R11: Outputs are registered. They reflect the request of the previous cycle, and all are zero in the cycle after a cycle without `req_valid`.
- R12: `addr_ok` and `fault` are never high together, and `fault` is high exactly when `fault_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target: 0 global, 1 local table |
| wr_idx | input | 13 | Entry index to write |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 20 | Raw segment limit |
| wr_gran | input | 1 | Granularity: 1 means 4 KB units |
| wr_dpl | input | 2 | Descriptor privilege level |
| wr_present | input | 1 | Present flag |
| req_valid | input | 1 | Translation request strobe |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Offset into the segment |
| cur_pl | input | 2 | Current privilege level |
| narrow | input | 1 | 1 limits the address to 24 bits |
| addr_ok | output | 1 | Linear address is valid |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Request refused |
| fault_code | output | 3 | 0 none, 1 null, 2 not present, 3 privilege, 4 limit |

## Verification
The clocked properties assume that `req_valid` and the selector fields are defined in every cycle after reset. They also assume that the outputs are judged only in the cycle after a request. The bench drives every input at the falling edge, holds `req_valid` for one cycle per request, and keeps it low while loading descriptors. The null-selector and narrow-mode properties therefore always see a complete request. The fault-priority cases are built from entries whose faults overlap on purpose.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int GDT_DEPTH = 8,
  parameter int LDT_DEPTH = 8,
  parameter int NARROW_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_local,
  input  logic [12:0] wr_idx,
  input  logic [31:0] wr_base,
  input  logic [19:0] wr_limit,
  input  logic        wr_gran,
  input  logic [1:0]  wr_dpl,
  input  logic        wr_present,
  input  logic        req_valid,
  input  logic [15:0] sel,
  input  logic [31:0] offset,
  input  logic [1:0]  cur_pl,
  input  logic        narrow,
  output logic        addr_ok,
  output logic [31:0] lin_addr,
  output logic        fault,
  output logic [2:0]  fault_code
);

  localparam int ENT_W = 56;
  localparam int GI_W  = (GDT_DEPTH > 1) ? $clog2(GDT_DEPTH) : 1;
  localparam int LI_W  = (LDT_DEPTH > 1) ? $clog2(LDT_DEPTH) : 1;
  localparam logic [2:0] F_NONE = 3'd0, F_NULL = 3'd1, F_NP = 3'd2,
                         F_PRIV = 3'd3, F_LIM = 3'd4;

  logic [ENT_W-1:0] gdt [GDT_DEPTH];
  logic [ENT_W-1:0] ldt [LDT_DEPTH];

  wire wr_g_in = {19'b0, wr_idx} < 32'(GDT_DEPTH);
  wire wr_l_in = {19'b0, wr_idx} < 32'(LDT_DEPTH);
  wire [ENT_W-1:0] wr_ent = {wr_present, wr_dpl, wr_gran, wr_limit, wr_base};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GDT_DEPTH; i++) gdt[i] <= '0;
      for (int i = 0; i < LDT_DEPTH; i++) ldt[i] <= '0;
    end else if (wr_en) begin
      if (!wr_local && wr_g_in) gdt[wr_idx[GI_W-1:0]] <= wr_ent;
      if ( wr_local && wr_l_in) ldt[wr_idx[LI_W-1:0]] <= wr_ent;
    end
  end

  wire [12:0] idx = sel[15:3];
  wire        ti  = sel[2];
  wire [1:0]  rpl = sel[1:0];
  wire g_in = {19'b0, idx} < 32'(GDT_DEPTH);
  wire l_in = {19'b0, idx} < 32'(LDT_DEPTH);

  logic [ENT_W-1:0] ent;
  always_comb begin
    ent = '0;
    if (ti && l_in)       ent = ldt[idx[LI_W-1:0]];
    else if (!ti && g_in) ent = gdt[idx[GI_W-1:0]];
  end

  wire [31:0] e_base    = ent[31:0];
  wire [19:0] e_limit   = ent[51:32];
  wire        e_gran    = ent[52];
  wire [1:0]  e_dpl     = ent[54:53];
  wire        e_present = ent[55];

  wire [31:0] seg_end = e_gran ? {e_limit, 12'hFFF} : {12'h000, e_limit};
  wire [1:0]  eff_pl  = (cur_pl > rpl) ? cur_pl : rpl;
  wire [31:0] sum     = e_base + offset;
  wire [31:0] nmask   = {{(32-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [2:0] code;
  always_comb begin
    if (!ti && idx == '0)     code = F_NULL;
    else if (!e_present)      code = F_NP;
    else if (eff_pl > e_dpl)  code = F_PRIV;
    else if (offset > seg_end) code = F_LIM;
    else                      code = F_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      addr_ok    <= 1'b0;
      lin_addr   <= '0;
      fault      <= 1'b0;
      fault_code <= F_NONE;
    end else begin
      addr_ok    <= (code == F_NONE);
      lin_addr   <= (code == F_NONE) ? (narrow ? (sum & nmask) : sum) : '0;
      fault      <= (code != F_NONE);
      fault_code <= code;
    end
  end

endmodule

module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] sel,
  input logic        narrow,
  input logic        addr_ok,
  input logic [31:0] lin_addr,
  input logic        fault,
  input logic [2:0]  fault_code
);
  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(addr_ok && fault));
  // R12
  code_chk: assert property (@(posedge clk) disable iff (!rst_n) fault == (fault_code != 3'd0));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_ok && !fault && lin_addr == 32'd0));
  // R4
  null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel[15:2] == 14'd0) |=> (fault && fault_code == 3'd1));
  // R10
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && narrow) |=> lin_addr[31:24] == 8'd0);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_local = 0, wr_gran = 0, wr_present = 0;
  logic [12:0] wr_idx = 0;
  logic [31:0] wr_base = 0, offset = 0;
  logic [19:0] wr_limit = 0;
  logic [1:0] wr_dpl = 0, cur_pl = 0;
  logic req_valid = 0, narrow = 0;
  logic [15:0] sel = 0;
  logic addr_ok, fault;
  logic [31:0] lin_addr;
  logic [2:0] fault_code;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  seg_xlate uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input bit loc, input int i, input logic [31:0] b, input logic [19:0] l,
                      input bit g, input logic [1:0] d, input bit p);
    @(negedge clk);
    wr_en = 1; wr_local = loc; wr_idx = 13'(i); wr_base = b; wr_limit = l;
    wr_gran = g; wr_dpl = d; wr_present = p;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic xlate(input logic [15:0] s, input logic [31:0] o, input logic [1:0] c,
                       input bit n, input logic [2:0] exp_code, input logic [31:0] exp_addr,
                       input string req);
    @(negedge clk);
    req_valid = 1; sel = s; offset = o; cur_pl = c; narrow = n;
    @(negedge clk);
    req_valid = 0;
    chk(fault_code == exp_code, req, 64'(fault_code), 64'(exp_code));
    chk(addr_ok == (exp_code == 0) && fault == (exp_code != 0), {req, " R12"},
        {62'b0, addr_ok, fault}, {62'b0, exp_code == 0, exp_code != 0});
    if (exp_code == 0) chk(lin_addr == exp_addr, req, 64'(lin_addr), 64'(exp_addr));
  endtask

  function automatic logic [15:0] mk(input int i, input bit loc, input logic [1:0] r);
    return {13'(i), loc, r};
  endfunction

  task automatic t_reset();
    chk(!addr_ok && !fault && lin_addr == 0 && fault_code == 0, "R1 outputs", 64'(lin_addr), 0);
    xlate(mk(1, 0, 0), 0, 0, 0, 3'd2, 0, "R1 empty global");
    xlate(mk(1, 1, 0), 0, 0, 0, 3'd2, 0, "R1 empty local");
  endtask

  task automatic t_granular();
    load(0, 1, 32'h2300_0000, 20'h012FF, 1, 2'd3, 1);
    xlate(mk(1, 0, 0), 32'h012F_FFFF, 0, 0, 3'd0, 32'h242F_FFFF, "R7 R9 R2 gran end");
    xlate(mk(1, 0, 0), 32'h0130_0000, 0, 0, 3'd4, 0, "R7 gran past end");
    xlate(mk(1, 0, 3), 32'h10, 3, 0, 3'd0, 32'h2300_0010, "R6 equal level");
  endtask

  task automatic t_local();
    load(1, 1, 32'h0010_0000, 20'h00FFF, 0, 2'd0, 1);
    xlate(mk(1, 1, 0), 32'h10, 0, 0, 3'd0, 32'h0010_0010, "R3 local table");
    xlate(mk(1, 1, 0), 32'h0FFF, 0, 0, 3'd0, 32'h0010_0FFF, "R7 byte end");
    xlate(mk(1, 1, 0), 32'h1000, 0, 0, 3'd4, 0, "R7 byte past end");
    xlate(mk(1, 1, 0), 32'h10, 1, 0, 3'd3, 0, "R6 cur level");
    xlate(mk(1, 1, 1), 32'h10, 0, 0, 3'd3, 0, "R6 requested level");
  endtask

  task automatic t_null();
    xlate(16'h0000, 0, 0, 0, 3'd1, 0, "R4 null");
    xlate(16'h0003, 0, 3, 0, 3'd1, 0, "R4 null rpl3");
    load(1, 0, 32'h0000_5000, 20'hFFFFF, 0, 2'd3, 1);
    xlate(mk(0, 1, 0), 32'h5, 0, 0, 3'd0, 32'h0000_5005, "R4 local index 0");
  endtask

  task automatic t_absent();
    xlate(mk(2, 1, 0), 0, 0, 0, 3'd2, 0, "R5 not loaded");
    load(0, 9, 32'h1000, 20'hFFFFF, 0, 2'd3, 1);
    xlate(mk(9, 0, 0), 0, 0, 0, 3'd2, 0, "R5 R2 beyond depth");
    load(0, 5, 32'h1000, 20'hFFFFF, 0, 2'd3, 0);
    xlate(mk(5, 0, 0), 0, 0, 0, 3'd2, 0, "R5 present clear");
  endtask

  task automatic t_priority();
    load(0, 2, 32'h0, 20'h1, 0, 2'd0, 0);
    xlate(mk(2, 0, 3), 32'hFFFF, 3, 0, 3'd2, 0, "R8 np over priv");
    load(0, 3, 32'h0, 20'h1, 0, 2'd0, 1);
    xlate(mk(3, 0, 3), 32'hFFFF, 3, 0, 3'd3, 0, "R8 priv over limit");
    xlate(16'h0003, 32'hFFFF, 3, 0, 3'd1, 0, "R8 null first");
  endtask

  task automatic t_narrow_wrap();
    load(0, 4, 32'h12F0_0000, 20'hFFFFF, 1, 2'd3, 1);
    xlate(mk(4, 0, 0), 32'h345, 0, 1, 3'd0, 32'h00F0_0345, "R10 narrow");
    xlate(mk(4, 0, 0), 32'h345, 0, 0, 3'd0, 32'h12F0_0345, "R10 wide");
    load(0, 6, 32'hFFFF_F000, 20'hFFFFF, 1, 2'd3, 1);
    xlate(mk(6, 0, 0), 32'h2000, 0, 0, 3'd0, 32'h0000_1000, "R9 wrap");
  endtask

  task automatic t_idle();
    xlate(mk(1, 0, 0), 32'h4, 0, 0, 3'd0, 32'h2300_0004, "R11 request");
    @(negedge clk);
    chk(!addr_ok && !fault && lin_addr == 0, "R11 idle", 64'(lin_addr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_granular();
    t_local();
    t_null();
    t_absent();
    t_priority();
    t_narrow_wrap();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule